// File: doc/BRIEF.md
# Virtual Page Tracker with Per-Line Location Table

This block is a set-associative tracker of recently used virtual pages. Each entry keeps a virtual tag, the physical page number it maps to, and a small table with one slot per cache line of the page. A slot records which cache level currently holds that line and in which way. A lookup presents a 48-bit virtual address. The block answers hit or miss, together with the level code and way of the addressed line, so a core can go straight to the right cache array without a tag search.

On a miss the block stops accepting lookups and picks a victim in the indexed set. If the victim is live, its table is written back to the physically tagged hub that owns the page. The block then asks a translator for the physical page, fetches that page's table from the hub, installs the new entry and finally tells the hub where the entry now lives by sending a back-pointer. Two side ports keep the tables current while they are in use. One rewrites a single slot when a cache line moves between levels. The other drops an entry named by its back-pointer.

The associativity parameter may be set to -1, which places every entry in a single set. Geometry, line size, page size and cache way count are parameters.

Top module: `ptrk_top`

## Requirements
- R1: After reset, lk_ready is 1, rsp_valid and every outgoing request valid (wb_valid, tr_req_valid, hf_req_valid, ln_valid) are 0, and every entry is invalid, so the first lookup misses.
- R2: With the default geometry (256-byte lines, 4 KiB pages, 8 sets), the address splits as byte offset [7:0], line index [11:8], set index [14:12] and tag [47:15]. The translator request carries address bits [47:12], which are the tag followed by the set.
- R3: A lookup accepted while lk_valid and lk_ready are both 1 is a hit when a valid entry in its set holds an equal tag. In the next cycle rsp_valid is 1 with rsp_hit 1 and the slot of the addressed line, and lk_ready stays 1.
- R4: On a miss the block issues, one at a time and in this order: an optional writeback, a translator request, and a hub fetch carrying the returned page number. The fetched table is installed in the victim, and one cycle after the link handshake rsp_valid is 1 with rsp_hit 0 and the addressed slot of the installed table.
- R5: From the cycle after a miss is accepted until the cycle its response is shown, lk_ready is 0 and no lookup is accepted.
- R6: The victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the way whose last lookup (hit or fill) is oldest, counted by a counter that advances once per accepted lookup.
- R7: If the victim is valid, a writeback carrying its back-pointer, its page number and its current table is sent before the translator request.
- R8: After installing an entry, the block sends a link with back-pointer (way << set-index width) | set and the new page number. The same value addresses the entry on the update and invalidate ports.
- R9: A table has one 6-bit slot per line. Line l sits at bits [6l+5:6l], with the level code in the top 2 bits (0 not cached, 1 first-level instruction, 2 first-level data, 3 second level) and the cache way in the low 4 bits.
- R10: An update (up_valid) rewrites the slot up_line of entry up_ptr. Lookups in later cycles return the new slot, and a hit accepted in the same cycle returns the old slot.
- R11: An invalidate (inv_valid) clears the valid bit of entry inv_ptr. A later lookup of that page misses, and that way is refilled without any writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted (idle) |
| lk_vaddr | input | 48 | Virtual address of the lookup |
| rsp_valid | output | 1 | One-cycle lookup result |
| rsp_hit | output | 1 | 1 for a hit, 0 for a completed miss |
| rsp_loc | output | 2 | Level code of the addressed line |
| rsp_way | output | 4 | Cache way of the addressed line |
| up_valid | input | 1 | Slot update strobe |
| up_ptr | input | 6 | Back-pointer of the entry to update |
| up_line | input | 4 | Line index within the page |
| up_loc | input | 2 | New level code |
| up_way | input | 4 | New cache way |
| inv_valid | input | 1 | Invalidate strobe |
| inv_ptr | input | 6 | Back-pointer of the entry to invalidate |
| wb_valid | output | 1 | Writeback to hub pending |
| wb_ready | input | 1 | Hub accepts writeback |
| wb_ptr | output | 6 | Back-pointer of the evicted entry |
| wb_ppn | output | 36 | Page number of the evicted entry |
| wb_table | output | 96 | Table of the evicted entry |
| tr_req_valid | output | 1 | Translation request pending |
| tr_req_ready | input | 1 | Translator accepts request |
| tr_vpn | output | 36 | Virtual page (tag and set) to translate |
| tr_rsp_valid | input | 1 | Translation result present |
| tr_rsp_ppn | input | 36 | Physical page number |
| hf_req_valid | output | 1 | Hub table fetch pending |
| hf_req_ready | input | 1 | Hub accepts fetch |
| hf_ppn | output | 36 | Page whose table is fetched |
| hf_rsp_valid | input | 1 | Fetched table present |
| hf_rsp_table | input | 96 | Fetched table |
| ln_valid | output | 1 | Link to hub pending |
| ln_ready | input | 1 | Hub accepts link |
| ln_ptr | output | 6 | Back-pointer of the installed entry |
| ln_ppn | output | 36 | Page number of the installed entry |

## Verification
A slot update and a lookup hit on the same slot can land in the same cycle. The bench drives up_valid and lk_valid on the same clock for one entry and line. It expects the response to carry the slot as it stood before the update, and a repeat lookup one cycle later to carry the new value. An invalidate and the later refill of the same way also meet. This case is judged by the absence of a writeback and by the link naming the invalidated back-pointer.

// File: rtl/ptrk_pkg.sv
package ptrk_pkg;

    localparam int VA_W = 48;

    typedef enum logic [1:0] {
        LOC_NONE = 2'd0,
        LOC_L1I  = 2'd1,
        LOC_L1D  = 2'd2,
        LOC_L2   = 2'd3
    } loc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_XREQ,
        ST_XRSP,
        ST_HREQ,
        ST_HRSP,
        ST_LINK
    } state_e;

    function automatic int eff_ways(input int entries, input int ways);
        return (ways < 0) ? entries : ways;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/ptrk_match.sv
module ptrk_match #(
    parameter int ENTRIES = 64,
    parameter int NW      = 8,
    parameter int SETS    = 8,
    parameter int TAG_W   = 33,
    parameter int PTR_W   = 6,
    parameter int SETF_W  = 3
) (
    input  logic                ent_valid [ENTRIES],
    input  logic [TAG_W-1:0]    ent_tag   [ENTRIES],
    input  logic [SETF_W-1:0]   set_idx,
    input  logic [TAG_W-1:0]    tag,
    output logic                hit,
    output logic [PTR_W-1:0]    hit_ptr
);

    logic [NW-1:0] eq;

    for (genvar w = 0; w < NW; w++) begin : g_way
        logic [PTR_W-1:0] ix;
        assign ix    = PTR_W'(w * SETS) + PTR_W'(set_idx);
        assign eq[w] = ent_valid[ix] && (ent_tag[ix] == tag);
    end

    always_comb begin
        hit     = |eq;
        hit_ptr = '0;
        for (int w = NW - 1; w >= 0; w--) begin
            if (eq[w]) hit_ptr = PTR_W'(w * SETS) + PTR_W'(set_idx);
        end
    end

endmodule

// File: rtl/ptrk_victim.sv
module ptrk_victim #(
    parameter int ENTRIES = 64,
    parameter int NW      = 8,
    parameter int SETS    = 8,
    parameter int TS_W    = 32,
    parameter int PTR_W   = 6,
    parameter int SETF_W  = 3
) (
    input  logic                ent_valid [ENTRIES],
    input  logic [TS_W-1:0]     ent_ts    [ENTRIES],
    input  logic [SETF_W-1:0]   set_idx,
    output logic [PTR_W-1:0]    vic_ptr,
    output logic                vic_live
);

    always_comb begin
        logic             found;
        logic [TS_W-1:0]  oldest;
        logic [PTR_W-1:0] ix;
        found   = 1'b0;
        vic_ptr = PTR_W'(set_idx);
        oldest  = ent_ts[PTR_W'(set_idx)];
        for (int w = 0; w < NW; w++) begin
            ix = PTR_W'(w * SETS) + PTR_W'(set_idx);
            if (!found && !ent_valid[ix]) begin
                found   = 1'b1;
                vic_ptr = ix;
            end
        end
        if (!found) begin
            for (int w = 1; w < NW; w++) begin
                ix = PTR_W'(w * SETS) + PTR_W'(set_idx);
                if (ent_ts[ix] < oldest) begin
                    oldest  = ent_ts[ix];
                    vic_ptr = ix;
                end
            end
        end
        vic_live = !found;
    end

endmodule

// File: rtl/ptrk_top.sv
module ptrk_top
    import ptrk_pkg::*;
#(
    parameter int ENTRIES    = 64,
    parameter int WAYS       = 8,
    parameter int PAGE_BYTES = 4096,
    parameter int LINE_BYTES = 256,
    parameter int CACHE_WAYS = 16,
    parameter int PA_W       = 48,
    parameter int TS_W       = 32,
    localparam int NW      = eff_ways(ENTRIES, WAYS),
    localparam int SETS    = ENTRIES / NW,
    localparam int SET_W   = $clog2(SETS),
    localparam int SETF_W  = at_least_one(SET_W),
    localparam int OFF_W   = $clog2(LINE_BYTES),
    localparam int PGB_W   = $clog2(PAGE_BYTES),
    localparam int PG_W    = PGB_W - OFF_W,
    localparam int LINES   = 1 << PG_W,
    localparam int TAG_W   = VA_W - PGB_W - SET_W,
    localparam int VPN_W   = VA_W - PGB_W,
    localparam int PPN_W   = PA_W - PGB_W,
    localparam int PTR_W   = $clog2(ENTRIES),
    localparam int CW      = $clog2(CACHE_WAYS),
    localparam int SLOT_W  = CW + 2,
    localparam int TBL_W   = LINES * SLOT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_valid,
    output logic                lk_ready,
    input  logic [VA_W-1:0]     lk_vaddr,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [1:0]          rsp_loc,
    output logic [CW-1:0]       rsp_way,
    input  logic                up_valid,
    input  logic [PTR_W-1:0]    up_ptr,
    input  logic [PG_W-1:0]     up_line,
    input  logic [1:0]          up_loc,
    input  logic [CW-1:0]       up_way,
    input  logic                inv_valid,
    input  logic [PTR_W-1:0]    inv_ptr,
    output logic                wb_valid,
    input  logic                wb_ready,
    output logic [PTR_W-1:0]    wb_ptr,
    output logic [PPN_W-1:0]    wb_ppn,
    output logic [TBL_W-1:0]    wb_table,
    output logic                tr_req_valid,
    input  logic                tr_req_ready,
    output logic [VPN_W-1:0]    tr_vpn,
    input  logic                tr_rsp_valid,
    input  logic [PPN_W-1:0]    tr_rsp_ppn,
    output logic                hf_req_valid,
    input  logic                hf_req_ready,
    output logic [PPN_W-1:0]    hf_ppn,
    input  logic                hf_rsp_valid,
    input  logic [TBL_W-1:0]    hf_rsp_table,
    output logic                ln_valid,
    input  logic                ln_ready,
    output logic [PTR_W-1:0]    ln_ptr,
    output logic [PPN_W-1:0]    ln_ppn
);

    typedef struct packed {
        loc_e          loc;
        logic [CW-1:0] way;
    } slot_t;

    // Entry storage, indexed by back-pointer (way * SETS + set)
    logic               ent_valid [ENTRIES];
    logic [TAG_W-1:0]   ent_tag   [ENTRIES];
    logic [PPN_W-1:0]   ent_ppn   [ENTRIES];
    logic [TS_W-1:0]    ent_ts    [ENTRIES];
    logic [TBL_W-1:0]   ent_tbl   [ENTRIES];

    state_e             st;
    logic [VA_W-1:0]    va_q;
    logic [PTR_W-1:0]   vic_q;
    logic [PPN_W-1:0]   ppn_q;
    logic [TS_W-1:0]    ts_cnt;

    // Address split of the incoming lookup
    logic [PG_W-1:0]    in_line;
    logic [SETF_W-1:0]  in_set;
    logic [TAG_W-1:0]   in_tag;
    logic [PG_W-1:0]    q_line;
    logic [TAG_W-1:0]   q_tag;

    assign in_line = lk_vaddr[OFF_W +: PG_W];
    assign in_set  = (SET_W == 0) ? '0 : lk_vaddr[PGB_W +: SETF_W];
    assign in_tag  = lk_vaddr[VA_W-1 -: TAG_W];
    assign q_line  = va_q[OFF_W +: PG_W];
    assign q_tag   = va_q[VA_W-1 -: TAG_W];

    logic               hit;
    logic [PTR_W-1:0]   hit_ptr;
    logic [PTR_W-1:0]   vic_ptr;
    logic               vic_live;
    logic               accept;
    slot_t              hit_slot;
    slot_t              fill_slot;

    ptrk_match #(
        .ENTRIES(ENTRIES), .NW(NW), .SETS(SETS),
        .TAG_W(TAG_W), .PTR_W(PTR_W), .SETF_W(SETF_W)
    ) u_match (
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .set_idx   (in_set),
        .tag       (in_tag),
        .hit       (hit),
        .hit_ptr   (hit_ptr)
    );

    ptrk_victim #(
        .ENTRIES(ENTRIES), .NW(NW), .SETS(SETS),
        .TS_W(TS_W), .PTR_W(PTR_W), .SETF_W(SETF_W)
    ) u_victim (
        .ent_valid (ent_valid),
        .ent_ts    (ent_ts),
        .set_idx   (in_set),
        .vic_ptr   (vic_ptr),
        .vic_live  (vic_live)
    );

    assign lk_ready  = (st == ST_IDLE);
    assign accept    = lk_valid && lk_ready;
    assign hit_slot  = slot_t'(ent_tbl[hit_ptr][in_line * SLOT_W +: SLOT_W]);
    assign fill_slot = slot_t'(ent_tbl[vic_q][q_line * SLOT_W +: SLOT_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_loc   <= '0;
            rsp_way   <= '0;
            ts_cnt    <= '0;
            va_q      <= '0;
            vic_q     <= '0;
            ppn_q     <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                ent_valid[e] <= 1'b0;
                ent_ts[e]    <= '0;
            end
        end else begin
            rsp_valid <= 1'b0;
            if (up_valid) begin
                ent_tbl[up_ptr][up_line * SLOT_W +: SLOT_W] <= {up_loc, up_way};
            end
            if (inv_valid) begin
                ent_valid[inv_ptr] <= 1'b0;
            end
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        ts_cnt <= ts_cnt + 1'b1;
                        if (hit) begin
                            ent_ts[hit_ptr] <= ts_cnt + 1'b1;
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_loc   <= hit_slot.loc;
                            rsp_way   <= hit_slot.way;
                        end else begin
                            va_q   <= lk_vaddr;
                            vic_q  <= vic_ptr;
                            ent_ts[vic_ptr]    <= ts_cnt + 1'b1;
                            ent_valid[vic_ptr] <= 1'b0;
                            st <= vic_live ? ST_WBACK : ST_XREQ;
                        end
                    end
                end
                ST_WBACK: if (wb_ready)     st <= ST_XREQ;
                ST_XREQ:  if (tr_req_ready) st <= ST_XRSP;
                ST_XRSP: begin
                    if (tr_rsp_valid) begin
                        ppn_q <= tr_rsp_ppn;
                        st    <= ST_HREQ;
                    end
                end
                ST_HREQ:  if (hf_req_ready) st <= ST_HRSP;
                ST_HRSP: begin
                    if (hf_rsp_valid) begin
                        ent_tbl[vic_q]   <= hf_rsp_table;
                        ent_tag[vic_q]   <= q_tag;
                        ent_ppn[vic_q]   <= ppn_q;
                        ent_valid[vic_q] <= 1'b1;
                        st <= ST_LINK;
                    end
                end
                ST_LINK: begin
                    if (ln_ready) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        rsp_loc   <= fill_slot.loc;
                        rsp_way   <= fill_slot.way;
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign wb_valid     = (st == ST_WBACK);
    assign wb_ptr       = vic_q;
    assign wb_ppn       = ent_ppn[vic_q];
    assign wb_table     = ent_tbl[vic_q];
    assign tr_req_valid = (st == ST_XREQ);
    assign tr_vpn       = va_q[VA_W-1 -: VPN_W];
    assign hf_req_valid = (st == ST_HREQ);
    assign hf_ppn       = ppn_q;
    assign ln_valid     = (st == ST_LINK);
    assign ln_ptr       = vic_q;
    assign ln_ppn       = ppn_q;

endmodule

// File: rtl/ptrk_chk.sv
module ptrk_chk #(
    parameter int VPN_W = 36
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             wb_valid,
    input logic             tr_req_valid,
    input logic             tr_req_ready,
    input logic [VPN_W-1:0] tr_vpn,
    input logic             tr_rsp_valid,
    input logic             hf_req_valid,
    input logic             ln_valid,
    input logic             ln_ready
);

    a_r5_busy_blocks_lookup: assert property (@(posedge clk) disable iff (rst)
        (wb_valid || tr_req_valid || hf_req_valid || ln_valid) |-> !lk_ready);

    a_r4_one_request_at_a_time: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_valid, tr_req_valid, hf_req_valid, ln_valid}));

    a_r4_vpn_held_until_taken: assert property (@(posedge clk) disable iff (rst)
        (tr_req_valid && !tr_req_ready) |=> (tr_req_valid && $stable(tr_vpn)));

    a_r7_writeback_precedes_xlate: assert property (@(posedge clk) disable iff (rst)
        $rose(tr_req_valid) |-> ($past(wb_valid) || $past(lk_ready)));

    a_r4_fetch_follows_xlate: assert property (@(posedge clk) disable iff (rst)
        $rose(hf_req_valid) |-> $past(tr_rsp_valid));

    a_r8_miss_answer_after_link: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> $past(ln_valid && ln_ready));

    a_r3_hit_answer_from_idle: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> $past(lk_ready));

endmodule

bind ptrk_top ptrk_chk #(.VPN_W($bits(tr_vpn))) u_chk (
    .clk          (clk),
    .rst          (rst),
    .lk_ready     (lk_ready),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .wb_valid     (wb_valid),
    .tr_req_valid (tr_req_valid),
    .tr_req_ready (tr_req_ready),
    .tr_vpn       (tr_vpn),
    .tr_rsp_valid (tr_rsp_valid),
    .hf_req_valid (hf_req_valid),
    .ln_valid     (ln_valid),
    .ln_ready     (ln_ready)
);

// File: tb/tb_ptrk_top.sv
`timescale 1ns/1ps
module tb_ptrk_top;

    logic        clk = 0;
    logic        rst;
    logic        lk_valid, lk_ready;
    logic [47:0] lk_vaddr;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_loc;
    logic [3:0]  rsp_way;
    logic        up_valid;
    logic [5:0]  up_ptr;
    logic [3:0]  up_line;
    logic [1:0]  up_loc;
    logic [3:0]  up_way;
    logic        inv_valid;
    logic [5:0]  inv_ptr;
    logic        wb_valid, wb_ready;
    logic [5:0]  wb_ptr;
    logic [35:0] wb_ppn;
    logic [95:0] wb_table;
    logic        tr_req_valid, tr_req_ready;
    logic [35:0] tr_vpn;
    logic        tr_rsp_valid;
    logic [35:0] tr_rsp_ppn;
    logic        hf_req_valid, hf_req_ready;
    logic [35:0] hf_ppn;
    logic        hf_rsp_valid;
    logic [95:0] hf_rsp_table;
    logic        ln_valid, ln_ready;
    logic [5:0]  ln_ptr;
    logic [35:0] ln_ppn;

    always #2 clk = ~clk;

    ptrk_top dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_loc(rsp_loc), .rsp_way(rsp_way),
        .up_valid(up_valid), .up_ptr(up_ptr), .up_line(up_line), .up_loc(up_loc), .up_way(up_way),
        .inv_valid(inv_valid), .inv_ptr(inv_ptr),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_ptr(wb_ptr), .wb_ppn(wb_ppn), .wb_table(wb_table),
        .tr_req_valid(tr_req_valid), .tr_req_ready(tr_req_ready), .tr_vpn(tr_vpn),
        .tr_rsp_valid(tr_rsp_valid), .tr_rsp_ppn(tr_rsp_ppn),
        .hf_req_valid(hf_req_valid), .hf_req_ready(hf_req_ready), .hf_ppn(hf_ppn),
        .hf_rsp_valid(hf_rsp_valid), .hf_rsp_table(hf_rsp_table),
        .ln_valid(ln_valid), .ln_ready(ln_ready), .ln_ptr(ln_ptr), .ln_ppn(ln_ppn)
    );

    int total = 0;
    int bad   = 0;
    bit awaiting = 0;

    // Behavioural model of the tracker contents
    bit          m_valid [64];
    logic [32:0] m_tag   [64];
    logic [35:0] m_ppn   [64];
    int          m_ts    [64];
    logic [95:0] m_tbl   [64];
    int          m_clock = 0;

    // Observations made by the port responders
    bit          seen_wb, seen_ln;
    logic [5:0]  s_wb_ptr, s_ln_ptr;
    logic [35:0] s_wb_ppn, s_ln_ppn, s_vpn, s_hppn;
    logic [95:0] s_wb_tbl;
    bit          tr_due, hf_due;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] xlate(input logic [35:0] vpn);
        return vpn ^ 36'h5A5A_5A5A5;
    endfunction

    function automatic logic [95:0] hub_table(input logic [35:0] ppn);
        logic [95:0] t;
        for (int l = 0; l < 16; l++) begin
            logic [1:0] lc;
            logic [3:0] wy;
            lc = ppn[1:0] + 2'(l);
            wy = ppn[7:4] + 4'(l * 5);
            t[l*6 +: 6] = {lc, wy};
        end
        return t;
    endfunction

    function automatic logic [47:0] mk_addr(input logic [32:0] tag, input int set, input int line);
        return {tag, 3'(set), 4'(line), 8'h3C};
    endfunction

    function automatic int find_entry(input logic [32:0] tag, input int set);
        for (int w = 0; w < 8; w++) begin
            if (m_valid[w*8 + set] && m_tag[w*8 + set] == tag) return w*8 + set;
        end
        return -1;
    endfunction

    // Responders: all request readies are held high
    initial begin
        tr_rsp_valid = 0; hf_rsp_valid = 0; tr_due = 0; hf_due = 0;
        tr_rsp_ppn = '0; hf_rsp_table = '0;
        forever begin
            @(negedge clk);
            tr_rsp_valid = 0;
            hf_rsp_valid = 0;
            if (tr_due) begin tr_rsp_valid = 1; tr_rsp_ppn = xlate(s_vpn); tr_due = 0; end
            if (hf_due) begin hf_rsp_valid = 1; hf_rsp_table = hub_table(s_hppn); hf_due = 0; end
            if (tr_req_valid) begin s_vpn = tr_vpn; tr_due = 1; end
            if (hf_req_valid) begin s_hppn = hf_ppn; hf_due = 1; end
            if (wb_valid) begin seen_wb = 1; s_wb_ptr = wb_ptr; s_wb_ppn = wb_ppn; s_wb_tbl = wb_table; end
            if (ln_valid) begin seen_ln = 1; s_ln_ptr = ln_ptr; s_ln_ppn = ln_ppn; end
        end
    end

    // Every clock: no response may appear outside a lookup window
    always @(posedge clk) begin
        if (!rst && rsp_valid && !awaiting) begin
            total++; bad++;
            $display("FAIL R3 unexpected response actual=1 expected=0");
        end
    end

    // Lookup, optionally with a same-cycle slot update
    task automatic lookup(input logic [32:0] tag, input int set, input int line,
                          input bit with_up, input int u_ptr, input int u_line,
                          input logic [1:0] u_loc, input logic [3:0] u_way);
        int p, vic;
        bit exp_wb, busy_ok;
        logic [5:0] exp_slot;
        logic [35:0] vpn, ppn;
        p = find_entry(tag, set);
        seen_wb = 0; seen_ln = 0;
        @(negedge clk);
        awaiting = 1;
        lk_valid = 1; lk_vaddr = mk_addr(tag, set, line);
        if (with_up) begin
            up_valid = 1; up_ptr = 6'(u_ptr); up_line = 4'(u_line); up_loc = u_loc; up_way = u_way;
        end
        @(negedge clk);
        lk_valid = 0; up_valid = 0;
        m_clock++;
        if (p >= 0) begin
            exp_slot = m_tbl[p][line*6 +: 6];
            m_ts[p] = m_clock;
            if (with_up) m_tbl[u_ptr][u_line*6 +: 6] = {u_loc, u_way};
            check(rsp_valid && rsp_hit, "R3 hit response", {rsp_valid, rsp_hit}, 2'b11);
            check({rsp_loc, rsp_way} == exp_slot, "R9/R10 hit slot", {rsp_loc, rsp_way}, exp_slot);
            check(lk_ready, "R3 ready after hit", lk_ready, 1);
        end else begin
            if (with_up) m_tbl[u_ptr][u_line*6 +: 6] = {u_loc, u_way};
            vic = -1;
            for (int w = 0; w < 8; w++) if (vic < 0 && !m_valid[w*8 + set]) vic = w*8 + set;
            exp_wb = (vic < 0);
            if (vic < 0) begin
                vic = set;
                for (int w = 1; w < 8; w++) if (m_ts[w*8 + set] < m_ts[vic]) vic = w*8 + set;
            end
            check(!rsp_valid && !lk_ready, "R5 miss blocks lookups", {rsp_valid, lk_ready}, 0);
            busy_ok = 1;
            for (int i = 0; i < 40 && !rsp_valid; i++) begin
                @(negedge clk);
                if (!rsp_valid && lk_ready) busy_ok = 0;
            end
            vpn = {tag, 3'(set)};
            ppn = xlate(vpn);
            exp_slot = hub_table(ppn)[line*6 +: 6];
            check(busy_ok, "R5 ready low during miss", busy_ok, 1);
            check(rsp_valid && !rsp_hit, "R4 miss response", {rsp_valid, rsp_hit}, 2'b10);
            check({rsp_loc, rsp_way} == exp_slot, "R4/R9 filled slot", {rsp_loc, rsp_way}, exp_slot);
            check(s_vpn == vpn, "R2 translator page", s_vpn, vpn);
            check(seen_wb == exp_wb, "R6/R7 writeback presence", seen_wb, exp_wb);
            if (exp_wb) begin
                check(s_wb_ptr == 6'(vic), "R6 victim pointer", s_wb_ptr, vic);
                check(s_wb_ppn == m_ppn[vic], "R7 writeback page", s_wb_ppn, m_ppn[vic]);
                check(s_wb_tbl == m_tbl[vic], "R7 writeback table", s_wb_tbl, m_tbl[vic]);
            end
            check(seen_ln && s_ln_ptr == 6'(vic), "R8 link pointer", s_ln_ptr, vic);
            check(s_ln_ppn == ppn, "R8 link page", s_ln_ppn, ppn);
            m_valid[vic] = 1; m_tag[vic] = tag; m_ppn[vic] = ppn;
            m_tbl[vic] = hub_table(ppn); m_ts[vic] = m_clock;
        end
        @(negedge clk);
        awaiting = 0;
    endtask

    task automatic look(input logic [32:0] tag, input int set, input int line);
        lookup(tag, set, line, 0, 0, 0, 2'd0, 4'd0);
    endtask

    task automatic update(input int ptr, input int line, input logic [1:0] lc, input logic [3:0] wy);
        @(negedge clk);
        up_valid = 1; up_ptr = 6'(ptr); up_line = 4'(line); up_loc = lc; up_way = wy;
        @(negedge clk);
        up_valid = 0;
        m_tbl[ptr][line*6 +: 6] = {lc, wy};
    endtask

    task automatic invalidate(input int ptr);
        @(negedge clk);
        inv_valid = 1; inv_ptr = 6'(ptr);
        @(negedge clk);
        inv_valid = 0;
        m_valid[ptr] = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int p;
        rst = 1; lk_valid = 0; lk_vaddr = '0;
        up_valid = 0; up_ptr = '0; up_line = '0; up_loc = '0; up_way = '0;
        inv_valid = 0; inv_ptr = '0;
        wb_ready = 1; tr_req_ready = 1; hf_req_ready = 1; ln_ready = 1;
        for (int e = 0; e < 64; e++) begin m_valid[e] = 0; m_ts[e] = 0; m_tbl[e] = '0; m_tag[e] = '0; m_ppn[e] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check(lk_ready && !rsp_valid, "R1 idle after reset", {lk_ready, rsp_valid}, 2'b10);
        check(!wb_valid && !tr_req_valid && !hf_req_valid && !ln_valid, "R1 no requests",
              {wb_valid, tr_req_valid, hf_req_valid, ln_valid}, 0);

        // R1/R4/R8: first lookup misses and fills way 0 of set 2
        look(33'h0_0000_1000, 2, 5);
        // R3/R9: hit on another line of the same page
        look(33'h0_0000_1000, 2, 9);
        // Fill the rest of set 2
        for (int k = 0; k < 7; k++) look(33'h0_0000_2000 + 33'(k), 2, k);
        // Refresh the first page, then R6/R7: oldest filled way is evicted with writeback
        look(33'h0_0000_1000, 2, 0);
        look(33'h0_0000_3000, 2, 3);
        look(33'h0_0000_2000, 2, 3);
        // R2 boundary: all-ones tag, top set, top line; set 0 bottom line
        look(33'h1_FFFF_FFFF, 7, 15);
        look(33'h1_FFFF_FFFF, 7, 15);
        look(33'h0_0000_0000, 0, 0);
        // R10: slot update visible on the next lookup
        p = find_entry(33'h0_0000_1000, 2);
        update(p, 4, 2'd3, 4'hA);
        look(33'h0_0000_1000, 2, 4);
        // R10: lookup and update of the same slot in one cycle
        lookup(33'h0_0000_1000, 2, 7, 1, p, 7, 2'd1, 4'h6);
        look(33'h0_0000_1000, 2, 7);
        // R11: invalidate by back-pointer, then refill without writeback
        p = find_entry(33'h0_0000_2002, 2);
        invalidate(p);
        look(33'h0_0000_2002, 2, 11);
        look(33'h0_0000_2002, 2, 12);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule